// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Channel

This block is a single channel of a multi-channel PWM timer. It holds an active down counter and an active compare value. Software writes new values into a count buffer and a compare buffer, and these reach the active registers at only two moments. The first is a manual-update strobe. The second is an automatic reload when the counter passes zero in auto-reload mode. The counter decrements once for each clock on which the tick enable is high, so a shared prescaler outside the block sets the tick rate.

The channel runs in one of two modes. In auto-reload mode it keeps running, and each period lasts N+1 ticks for a loaded count N. In one-shot mode it stops at zero after a single pass. On every underflow it raises a one-cycle interrupt pulse. The PWM pin is derived from how the running count relates to the active compare value. An invert control bit flips the pin. Software can read the active count at any time.

Top module: `pwm_timer_chan`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the count reads 0, the interrupt is low, and the PWM pin equals the invert bit XOR 1.
- R2: The control input is a 4-bit field with bit 0 start, bit 1 manual update, bit 2 invert and bit 3 auto-reload.
- R3: On every clock with manual update set, the count buffer is copied into the active count and the compare buffer into the active compare. The one-shot stop state is cleared. No count step and no interrupt take place.
- R4: With start set, manual update clear and the channel not stopped, a clock with the tick enable high and a nonzero count lowers the count by exactly one.
- R5: In auto-reload mode, a tick taken at count 0 reloads both active values from the buffers. Consecutive interrupts are therefore N+1 ticks apart for a buffered count N.
- R6: In one-shot mode, a tick taken at count 0 raises the interrupt and leaves the count at 0. No further count change or interrupt occurs until a manual update.
- R7: The interrupt is high for exactly the one cycle after the clock edge at which a tick was taken at count 0. It is never high otherwise.
- R8: The PWM pin is 0 when the active count is greater than the active compare and 1 otherwise. The invert bit flips this level.
- R9: With start clear and manual update clear, the count holds its value, which stays readable, and no interrupt is raised.
- R10: A change to either buffer without a manual update or a reload leaves the running count and the PWM pin unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count qualifier from the prescaler |
| ctrl | input | 4 | Control field: start, manual update, invert, auto-reload |
| cnt_buf | input | CNT_W | Buffered count value |
| cmp_buf | input | CNT_W | Buffered compare value |
| pwm_out | output | 1 | PWM pin |
| cur_count | output | CNT_W | Active count, readable at any time |
| irq | output | 1 | One-cycle underflow interrupt pulse |

## Verification
The assertions assume that every input is a synchronous level sampled at the rising clock edge, that tick_en can be high on any number of consecutive cycles, and that any combination of the four control bits is legal, including manual update together with start. The stimulus satisfies these conditions by changing every input only on falling edges. It draws the control bits, the tick and small buffer values from a seeded generator, which makes count-zero and reload events frequent. Directed sequences cover the reset state, an exact reload period, a one-shot stop, a frozen count and buffer writes without an update.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  // Control field layout inside one channel nibble
  localparam int CTL_W = 4;

  typedef struct packed {
    logic arl;    // bit 3: reload at zero and keep running
    logic inv;    // bit 2: flip the pin level
    logic mupd;   // bit 1: copy buffers into active registers
    logic start;  // bit 0: allow counting
  } chan_ctl_t;

  // Pin level before inversion: low while count lies above compare
  function automatic logic pwm_level(input logic [63:0] cnt, input logic [63:0] cmp);
    return (cnt > cmp) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/pwmt_ctl_decode.sv
module pwmt_ctl_decode
  import pwmt_pkg::*;
(
  input  logic [CTL_W-1:0] ctrl,
  input  logic             tick_en,
  input  logic             stopped,
  output chan_ctl_t        ctl,
  output logic             step_ok
);
  assign ctl     = chan_ctl_t'(ctrl);
  // A count step is permitted only while running and not being loaded
  assign step_ok = ctl.start & ~ctl.mupd & tick_en & ~stopped;
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_ctl_t        ctl,
  input  logic             step_ok,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             stopped_q,
  output logic             uf_evt,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_zero;
  logic reload_evt;
  logic stop_evt;

  assign at_zero    = (cnt_q == '0);
  assign uf_evt     = step_ok & at_zero;
  assign reload_evt = uf_evt & ctl.arl;
  assign stop_evt   = uf_evt & ~ctl.arl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cmp_q     <= '0;
      stopped_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= uf_evt;
      if (ctl.mupd) begin
        cnt_q     <= cnt_buf;
        cmp_q     <= cmp_buf;
        stopped_q <= 1'b0;
      end else if (reload_evt) begin
        cnt_q <= cnt_buf;
        cmp_q <= cmp_buf;
      end else if (stop_evt) begin
        stopped_q <= 1'b1;
      end else if (step_ok) begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/pwmt_outgen.sv
module pwmt_outgen
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             inv,
  output logic             pwm
);
  logic [63:0] cnt_x;
  logic [63:0] cmp_x;

  generate
    if (CNT_W < 64) begin : g_pad
      assign cnt_x = {{(64-CNT_W){1'b0}}, cnt};
      assign cmp_x = {{(64-CNT_W){1'b0}}, cmp};
    end else begin : g_full
      assign cnt_x = cnt[63:0];
      assign cmp_x = cmp[63:0];
    end
  endgenerate

  assign pwm = pwm_level(cnt_x, cmp_x) ^ inv;
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_en,
  input  logic [pwmt_pkg::CTL_W-1:0] ctrl,
  input  logic [CNT_W-1:0]       cnt_buf,
  input  logic [CNT_W-1:0]       cmp_buf,
  output logic                   pwm_out,
  output logic [CNT_W-1:0]       cur_count,
  output logic                   irq
);
  chan_ctl_t        ctl_w;
  logic             step_w;
  logic             stopped_w;
  logic             uf_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cmp_w;
  logic             irq_w;

  pwmt_ctl_decode u_dec (
    .ctrl    (ctrl),
    .tick_en (tick_en),
    .stopped (stopped_w),
    .ctl     (ctl_w),
    .step_ok (step_w)
  );

  pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl_w),
    .step_ok   (step_w),
    .cnt_buf   (cnt_buf),
    .cmp_buf   (cmp_buf),
    .cnt_q     (cnt_w),
    .cmp_q     (cmp_w),
    .stopped_q (stopped_w),
    .uf_evt    (uf_w),
    .irq_q     (irq_w)
  );

  pwmt_outgen #(.CNT_W(CNT_W)) u_out (
    .cnt (cnt_w),
    .cmp (cmp_w),
    .inv (ctl_w.inv),
    .pwm (pwm_out)
  );

  assign cur_count = cnt_w;
  assign irq       = irq_w;
endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [3:0]       ctrl,
  input logic [CNT_W-1:0] cnt_buf,
  input logic [CNT_W-1:0] cmp_buf,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_act,
  input logic             stopped,
  input logic             irq,
  input logic             pwm
);
  logic st, mu, inv, arl, take;
  assign st   = ctrl[0];
  assign mu   = ctrl[1];
  assign inv  = ctrl[2];
  assign arl  = ctrl[3];
  assign take = st & ~mu & tick_en & ~stopped;

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mu |=> (count == $past(cnt_buf)) && (cmp_act == $past(cmp_buf)) && !irq && !stopped);

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && count != '0) |=> (count == $past(count) - CNT_W'(1)) && !irq);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && count == '0 && arl) |=> (count == $past(cnt_buf)) && irq);

  assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && count == '0 && !arl) |=> (count == '0) && irq && stopped);

  assert_stopped_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !mu) |=> $stable(count) && !irq);

  assert_irq_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(count) == '0);

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!st && !mu) |=> $stable(count) && !irq);

  assert_pin_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (pwm == !inv));
endmodule

bind pwm_timer_chan pwmt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_en (tick_en),
  .ctrl    (ctrl),
  .cnt_buf (cnt_buf),
  .cmp_buf (cmp_buf),
  .count   (cur_count),
  .cmp_act (cmp_w),
  .stopped (stopped_w),
  .irq     (irq),
  .pwm     (pwm_out)
);

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en = 1'b0;
  logic [3:0]   ctrl = 4'h0;
  logic [W-1:0] cnt_buf = '0;
  logic [W-1:0] cmp_buf = '0;
  logic         pwm_out;
  logic [W-1:0] cur_count;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // Reference state
  int m_cnt = 0, m_cmp = 0;
  bit m_stop = 0, m_irq = 0;

  always #2 clk = ~clk;

  pwm_timer_chan #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl(ctrl),
    .cnt_buf(cnt_buf), .cmp_buf(cmp_buf),
    .pwm_out(pwm_out), .cur_count(cur_count), .irq(irq)
  );

  function automatic bit exp_pin(int c, int k, bit flip);
    bit lvl = (c <= k);
    return lvl ^ flip;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called just after a falling edge: drive, let one rising edge pass, compare.
  task automatic cyc(bit st, bit mu, bit iv, bit ar, bit tk, int cb, int mb);
    string tag;
    ctrl = {ar, iv, mu, st};   // R2: bit0 start, bit1 update, bit2 invert, bit3 reload
    tick_en = tk; cnt_buf = W'(cb); cmp_buf = W'(mb);
    m_irq = 0;
    if (mu) begin
      m_cnt = cb; m_cmp = mb; m_stop = 0; tag = "R3";
    end else if (!st) begin
      tag = "R9";
    end else if (m_stop) begin
      tag = "R6";
    end else if (!tk) begin
      tag = "R10";
    end else if (m_cnt == 0) begin
      m_irq = 1;
      if (ar) begin m_cnt = cb; m_cmp = mb; tag = "R5"; end
      else begin m_stop = 1; tag = "R6"; end
    end else begin
      m_cnt = m_cnt - 1; tag = "R4";
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " count"}, int'(cur_count), m_cnt);
    chk({tag, " R7 irq"}, int'(irq), int'(m_irq));
    chk({tag, " R8 pin"}, int'(pwm_out), int'(exp_pin(m_cnt, m_cmp, iv)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int last_irq, gap, seen;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(cur_count), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 pin", int'(pwm_out), 1);

    // R5 exact period: N=3 gives 4 ticks between interrupts
    cyc(0, 1, 0, 1, 0, 3, 1);
    last_irq = -1; seen = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1, 0, 0, 1, 1, 3, 1);
      if (irq) begin
        if (last_irq >= 0) begin gap = i - last_irq; chk("R5 period", gap, 4); seen++; end
        last_irq = i;
      end
    end
    chk("R5 irq seen", int'(seen >= 3), 1);

    // R10 buffer writes without update do not disturb the count
    cyc(0, 1, 0, 1, 0, 9, 4);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 1, i % 2, 2 + i, 7 - i);
    chk("R10 count after buffer churn", int'(cur_count), 7);

    // R6 one-shot stop, then no further activity
    cyc(0, 1, 1, 0, 0, 2, 0);
    for (int i = 0; i < 8; i++) cyc(1, 0, 1, 0, 1, 5, 5);
    chk("R6 stays at zero", int'(cur_count), 0);

    // R9 freeze with start clear
    cyc(0, 1, 0, 0, 0, 6, 2);
    cyc(1, 0, 0, 0, 1, 6, 2);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 1, 1, 1);
    chk("R9 frozen value", int'(cur_count), 5);

    // R2 invert bit alone flips the pin
    cyc(0, 0, 1, 0, 0, 0, 0);
    chk("R2 invert at bit 2", int'(pwm_out), 1);

    // Random phase
    for (int i = 0; i < 2500; i++) begin
      bit st = ($urandom % 8) != 0;
      bit mu = ($urandom % 12) == 0;
      bit iv = $urandom % 2;
      bit ar = ($urandom % 4) != 0;
      bit tk = ($urandom % 3) != 0;
      cyc(st, mu, iv, ar, tk, $urandom % 8, $urandom % 8);
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule